// File: doc/BRIEF.md
# Gamepad Parallel-to-Serial Button Reporter

This block is the logic inside a game controller. A group of button levels is captured into a shift register and sent to the host one bit at a time over a three-wire link: the host drives a strobe line and a shift clock line, and the controller returns one serial data line. While the strobe is asserted, the register reloads from the live button levels on every cycle. Once the strobe is released, the captured report is frozen, and each rising edge of the shift clock moves the next button onto the data line.

The data line is active-low: a pressed button drives a 0 on the wire, and the inverter on the host side turns it into a 1. When every report bit has been shifted out, the last stage is fed either from a fixed fill level or from a serial cascade input. The fill level is set by a parameter, and its default of wire 0 reads as 1 on the host side. A parameter selects the 8-slot report or the 16-slot wide report. In the wide report, the four trailing slots always report as not pressed. All link inputs pass through a two-flop synchronizer that runs on the local clock.

Top module: `gpad_serial_reporter`

## Requirements
- R1: While reset is asserted, and directly after it, `data_n_o` is 1, which means no button is pressed.
- R2: While strobe is high, `data_n_o` shows the inverted live level of report slot 0 (`btn_i[0]`), and it follows changes to that input.
- R3: Rising shift-clock edges that arrive while strobe is high do not shift. After strobe is released, the first bit read is still slot 0.
- R4: After strobe is released, changes on `btn_i` have no effect on the report that is being shifted out.
- R5: Each rising edge of `sclk_i` with strobe low moves the next slot onto `data_n_o`, and a falling edge moves nothing. Slot k is `btn_i[k]`. In the 8-slot report the slots are ordered A, B, Select, Start, Up, Down, Left, Right (bits 0 to 7).
- R6: The wire is active-low. A pressed button (`btn_i` bit = 1) appears as 0 on `data_n_o`.
- R7: With cascading off, every read after the last report slot returns the wire level FILL_WIRE (default 0, which reads as 1 on the host side).
- R8: With cascading on, the bits after the last report slot are the values of `ser_i` shifted in, in the order they entered.
- R9: In the 16-slot report the slots are ordered B, Y, Select, Start, Up, Down, Left, Right, A, X, L, R (bits 0 to 11). Slots 12 to 15 always read as not pressed (wire 1), whatever `btn_i[15:12]` holds.
- R10: With strobe high, a change on a button input reaches `data_n_o` on the third rising edge of `clk_i` after the change, and not earlier. This delay is two synchronizer stages plus the register load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | REPORT_W | Button levels, 1 = pressed, bit k = report slot k |
| strobe_i | input | 1 | Host strobe: high reloads, low freezes for shifting |
| sclk_i | input | 1 | Host shift clock; a rising edge advances one slot |
| ser_i | input | 1 | Cascade serial input (wire level) |
| data_n_o | output | 1 | Serial report on the wire, active low |

## Verification
The hardest case to reach is a report that has been captured and then must stay fixed while its inputs keep moving. The stimulus pulses the shift clock while the strobe is still high, and it inverts every button right after the strobe falls. Any leak of the live inputs into the report then shows up as a wrong bit. Each report is read well past its end so that the fill bits and the cascade bits are checked, and two configurations run side by side: the 8-slot report with fixed fill, and the 16-slot report with cascading.

// File: rtl/gpad_pkg.sv
package gpad_pkg;
   localparam int STD_SLOTS  = 8;
   localparam int WIDE_SLOTS = 16;
   localparam int WIDE_USED  = 12;

   typedef enum logic [1:0] {
      SR_HOLD,
      SR_LOAD,
      SR_SHIFT
   } sr_op_e;

   // number of slots carrying real buttons for a given report width
   function automatic int used_slots(input int width);
      return (width == WIDE_SLOTS) ? WIDE_USED : width;
   endfunction
endpackage

// File: rtl/gpad_sync.sv
module gpad_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpad_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[0] <= '0;
            else         stage_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpad_edge.sv
module gpad_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

   // R5: one host edge yields a single step, never two back to back
   single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);
endmodule

// File: rtl/gpad_shifter.sv
module gpad_shifter #(
   parameter int   W          = 8,
   parameter int   USED       = 8,
   parameter bit   CASCADE_EN = 1'b0,
   parameter logic FILL_WIRE  = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         strb_i,
   input  logic         step_i,
   input  logic [W-1:0] btn_i,
   input  logic         ser_i,
   output logic         dout_o
);
   import gpad_pkg::*;

   logic [W-1:0] sr_q;
   logic [W-1:0] load_val;
   logic         fill_bit;
   sr_op_e       op;

   // pressed = 1 at the input becomes 0 on the wire; padding slots read idle
   for (genvar i = 0; i < W; i++) begin : g_slot
      assign load_val[i] = (i < USED) ? ~btn_i[i] : 1'b1;
   end

   assign fill_bit = CASCADE_EN ? ser_i : FILL_WIRE;

   always_comb begin
      if (strb_i)      op = SR_LOAD;
      else if (step_i) op = SR_SHIFT;
      else             op = SR_HOLD;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sr_q <= '1;
      end else begin
         case (op)
            SR_LOAD:  sr_q <= load_val;
            SR_SHIFT: sr_q <= {fill_bit, sr_q[W-1:1]};
            default:  sr_q <= sr_q;
         endcase
      end
   end

   assign dout_o = sr_q[0];

   // R2
   load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strb_i |=> (dout_o == !$past(btn_i[0])));

   // R4
   frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!strb_i && !step_i) |=> $stable(sr_q));

   // R5
   shift_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!strb_i && step_i) |=> (sr_q[W-2:0] == $past(sr_q[W-1:1])));

   // R7
   tail_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!strb_i && step_i) |=> (sr_q[W-1] == $past(fill_bit)));

   if (USED < W) begin : g_pad
      // R9
      pad_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         strb_i |=> (&sr_q[W-1:USED]));
   end
endmodule

// File: rtl/gpad_serial_reporter.sv
module gpad_serial_reporter #(
   parameter int   REPORT_W    = 8,
   parameter bit   CASCADE_EN  = 1'b0,
   parameter logic FILL_WIRE   = 1'b0,
   parameter int   SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [REPORT_W-1:0] btn_i,
   input  logic                strobe_i,
   input  logic                sclk_i,
   input  logic                ser_i,
   output logic                data_n_o
);
   import gpad_pkg::*;

   localparam int USED   = used_slots(REPORT_W);
   localparam int SYNC_W = REPORT_W + 3;

   if (REPORT_W != STD_SLOTS && REPORT_W != WIDE_SLOTS) begin : g_bad_width
      $error("gpad_serial_reporter: REPORT_W must be 8 or 16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpad_serial_reporter: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_W-1:0]   raw_in;
   logic [SYNC_W-1:0]   sync_out;
   logic [REPORT_W-1:0] btn_s;
   logic                strb_s, sclk_s, ser_s, step;

   assign raw_in = {ser_i, sclk_i, strobe_i, btn_i};
   assign {ser_s, sclk_s, strb_s, btn_s} = sync_out;

   gpad_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in),
      .q_o    (sync_out)
   );

   gpad_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (sclk_s),
      .rise_o (step)
   );

   gpad_shifter #(
      .W          (REPORT_W),
      .USED       (USED),
      .CASCADE_EN (CASCADE_EN),
      .FILL_WIRE  (FILL_WIRE)
   ) u_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .strb_i (strb_s),
      .step_i (step),
      .btn_i  (btn_s),
      .ser_i  (ser_s),
      .dout_o (data_n_o)
   );

   // R3
   strobe_no_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strb_s && $past(strb_s)) |-> (data_n_o == !$past(btn_s[0])));
endmodule

// File: tb/gpad_serial_reporter_tb.sv
module gpad_serial_reporter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] btn = '0;
   logic        strobe = 1'b0;
   logic        sclk = 1'b0;
   logic        ser = 1'b0;
   logic        d8, d16;
   int          n_chk = 0;
   int          n_fail = 0;
   int          cyc = 0;
   logic        done = 1'b0;

   always #4 clk = ~clk;

   gpad_serial_reporter #(.REPORT_W(8)) u_dut (
      .clk_i (clk), .rst_ni (rst_n), .btn_i (btn[7:0]), .strobe_i (strobe),
      .sclk_i (sclk), .ser_i (ser), .data_n_o (d8)
   );

   gpad_serial_reporter #(.REPORT_W(16), .CASCADE_EN(1'b1)) u_dut_w (
      .clk_i (clk), .rst_ni (rst_n), .btn_i (btn), .strobe_i (strobe),
      .sclk_i (sclk), .ser_i (ser), .data_n_o (d16)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b (time %0t)", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got cycle %0d expected finish earlier", cyc);
         report();
         $finish;
      end
   end

   function automatic logic exp8(input logic [15:0] b, input int k);
      return (k < 8) ? ~b[k] : 1'b0;          // R7 fill wire level 0
   endfunction

   function automatic logic exp16(input logic [15:0] b, input logic s, input int k);
      if (k < 12) return ~b[k];
      if (k < 16) return 1'b1;                // R9 padding idle
      return s;                               // R8 cascade
   endfunction

   initial begin
      logic [15:0] b;
      tick(3);
      // R1 during reset
      check("R1", d8, 1'b1);
      check("R1", d16, 1'b1);
      rst_n = 1'b1;
      tick(2);
      check("R1", d8, 1'b1);
      check("R1", d16, 1'b1);

      // R10 latency and R6 polarity
      strobe = 1'b1;
      btn = '0;
      tick(6);
      btn[0] = 1'b1;
      tick(2);
      check("R10", d8, 1'b1);
      check("R10", d16, 1'b1);
      tick(1);
      check("R10", d8, 1'b0);
      check("R6", d16, 1'b0);
      // R2 live follow back to released
      btn[0] = 1'b0;
      tick(4);
      check("R2", d8, 1'b1);
      strobe = 1'b0;
      tick(5);

      for (int p = 0; p < 256; p++) begin
         b = {~p[3:0], p[7:4] ^ p[3:0], p[7:0]};
         ser = p[1];
         btn = b;
         strobe = 1'b1;
         tick(5);
         check("R2", d8, ~b[0]);
         check("R2", d16, ~b[0]);
         // R3 shift clock while strobe high
         sclk = 1'b1;
         tick(4);
         check("R3", d8, ~b[0]);
         check("R3", d16, ~b[0]);
         sclk = 1'b0;
         tick(4);
         strobe = 1'b0;
         tick(5);
         // R4 inputs move after capture
         btn = ~b;
         tick(5);
         for (int k = 0; k < 18; k++) begin
            check((k < 8) ? "R5" : "R7", d8, exp8(b, k));
            check((k < 16) ? "R9" : "R8", d16, exp16(b, ser, k));
            if (k == 0) check("R4", d16, ~b[0]);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(4);
         end
      end

      done = 1'b1;
      report();
      $finish;
   end
endmodule